// File: doc/BRIEF.md
# Converter Self-Calibration Trigger Sequencer

This block decides when a data converter's self-calibration runs and reports progress to the rest of the chip. After the power-on reset is released it waits a power-up delay, then launches one automatic calibration. The delay has two lengths, and a single-bit select input chooses between them. If the calibrate request pin is seen high while the sequencer is still waiting for power-up, the automatic run is dropped. In that case nothing starts until an explicit request arrives.

An explicit request counts only after a qualified pattern on the request pin. The pin must first stay low for a run of `RUN_LEN` consecutive clock cycles, and then stay high for another `RUN_LEN` consecutive cycles. The pin is first passed through a two-flop synchronizer. Two counters filter out noise. The low-run counter saturates at its threshold. The high-run counter restarts whenever the pin level breaks the run. A calibration lasts `CAL_LEN` cycles, counted inside the block, unless the calibration engine ends it early with a done pulse. The block ignores the pin during a calibration and requires a fresh low-then-high pattern afterwards.

The controller has five states. `ST_PWR_WAIT` counts the power-up delay. It goes to `ST_LAUNCH` when the delay expires, or to `ST_SEEK_LOW` if the synchronized pin is high. `ST_SEEK_LOW` counts the low run. It goes to `ST_SEEK_HIGH` when a high level follows a full low run. `ST_SEEK_HIGH` counts the high run. It goes back to `ST_SEEK_LOW` on a low level, or to `ST_LAUNCH` after `RUN_LEN` high cycles. `ST_LAUNCH` lasts one cycle and always moves to `ST_CALIB`. `ST_CALIB` returns to `ST_SEEK_LOW` at the end of the count or on a done pulse.

Top module: `cal_trigger_seq`

## Requirements
- R1: While reset is asserted, and in the cycles after its release, `cal_start` and `cal_busy` are 0. With `dly_sel`=0 and the pin low, `cal_start` is high in the cycle that follows the `PWR_DLY_SHORT`-th rising edge after reset release.
- R2: With `dly_sel`=1, the automatic start comes after the `PWR_DLY_LONG`-th rising edge instead.
- R3: If the synchronized request pin is high before the power-up delay expires, no automatic calibration happens. A later qualified request still launches one.
- R4: A qualified request starts a calibration. The pin, as seen after the two-flop synchronizer, must be low for at least `RUN_LEN` cycles and then high for `RUN_LEN` cycles. If the first edge that samples the pin high is edge k, `cal_start` is high after edge k+`RUN_LEN`+1.
- R5: A low run or a high run shorter than `RUN_LEN` cycles never triggers a calibration. A broken run restarts its count.
- R6: `cal_start` is a single-cycle pulse. `cal_busy` rises in that same cycle and, without a done pulse, stays high for exactly `CAL_LEN` cycles.
- R7: If `cal_done` is high at a rising edge during a busy cycle after the start cycle, `cal_busy` is 0 in the next cycle.
- R8: Pin activity during a calibration is ignored. A low-then-high pattern that lies inside the busy period starts nothing afterwards.
- R9: If the pin is held high indefinitely, the block produces exactly one calibration.
- R10: If the clock is absent when reset is released, the power-up delay is counted from the first clock edge that arrives, and the timing is otherwise identical to R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| cal_req | input | 1 | Asynchronous calibrate request pin |
| dly_sel | input | 1 | Power-up delay select: 0 short, 1 long |
| cal_done | input | 1 | Early end-of-calibration pulse from the engine |
| cal_start | output | 1 | One-cycle pulse launching a calibration |
| cal_busy | output | 1 | High while a calibration is in progress |

## Verification
The automatic start is due after the delay-th edge following reset release. An on-command start is due `RUN_LEN`+1 edges after the first edge that samples the pin high, because two of those edges go to the synchronizer. Busy falls `CAL_LEN` cycles after the start, or one cycle after an accepted done pulse. A behavioural model in the bench keeps its own synchronizer, run counters and phase, and is stepped on every rising edge. The outputs are compared with the model at each falling edge. Scenario checks record the edge number of each start and the measured busy length, and compare them with the counts above.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [2:0] {
        ST_PWR_WAIT  = 3'd0,
        ST_SEEK_LOW  = 3'd1,
        ST_SEEK_HIGH = 3'd2,
        ST_LAUNCH    = 3'd3,
        ST_CALIB     = 3'd4
    } cal_state_e;
endpackage

// File: rtl/cal_req_sync.sv
module cal_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[0] <= 1'b0;
                    else         chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[i] <= 1'b0;
                    else         chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_dly_pick.sv
module cal_dly_pick #(
    parameter int SHORT_DLY = 40,
    parameter int LONG_DLY  = 90,
    parameter int CW        = 8
) (
    input  logic          sel,
    output logic [CW-1:0] limit
);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_DLY);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_DLY);

    always_comb begin
        limit = sel ? LONG_V : SHORT_V;
    end
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
    import cal_seq_pkg::*;
#(
    parameter int RUN_LEN = 10,
    parameter int CAL_LEN = 24,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          req_s,
    input  logic [CW-1:0] pwr_limit,
    input  logic          cal_done,
    output logic          cal_start,
    output logic          cal_busy
);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] RUN_K  = CW'(RUN_LEN);
    localparam logic [CW-1:0] RUN_M1 = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] CAL_M1 = CW'(CAL_LEN - 1);

    cal_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_PWR_WAIT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_PWR_WAIT: begin
                if (req_s) begin
                    state_nxt = ST_SEEK_LOW;
                    cnt_nxt   = '0;
                end else if (cnt == pwr_limit - ONE) begin
                    state_nxt = ST_LAUNCH;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            ST_SEEK_LOW: begin
                if (!req_s) begin
                    if (cnt != RUN_K) cnt_nxt = cnt + ONE;
                end else if (cnt == RUN_K) begin
                    state_nxt = ST_SEEK_HIGH;
                    cnt_nxt   = ONE;
                end else begin
                    cnt_nxt = '0;
                end
            end
            ST_SEEK_HIGH: begin
                if (!req_s) begin
                    state_nxt = ST_SEEK_LOW;
                    cnt_nxt   = ONE;
                end else if (cnt == RUN_M1) begin
                    state_nxt = ST_LAUNCH;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            ST_LAUNCH: begin
                state_nxt = ST_CALIB;
                cnt_nxt   = ONE;
            end
            ST_CALIB: begin
                if (cal_done || cnt == CAL_M1) begin
                    state_nxt = ST_SEEK_LOW;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            default: begin
                state_nxt = ST_PWR_WAIT;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cal_start = (state == ST_LAUNCH);
        cal_busy  = (state == ST_LAUNCH) || (state == ST_CALIB);
    end
endmodule

// File: rtl/cal_trigger_seq.sv
module cal_trigger_seq #(
    parameter int PWR_DLY_SHORT = 40,
    parameter int PWR_DLY_LONG  = 90,
    parameter int RUN_LEN       = 10,
    parameter int CAL_LEN       = 24,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic cal_req,
    input  logic dly_sel,
    input  logic cal_done,
    output logic cal_start,
    output logic cal_busy
);
    localparam int MAX_A = (PWR_DLY_SHORT > PWR_DLY_LONG) ? PWR_DLY_SHORT : PWR_DLY_LONG;
    localparam int MAX_B = (RUN_LEN > CAL_LEN) ? RUN_LEN : CAL_LEN;
    localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_V + 1);

    logic          req_s;
    logic [CW-1:0] pwr_limit;

    cal_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (cal_req),
        .q      (req_s)
    );

    cal_dly_pick #(
        .SHORT_DLY (PWR_DLY_SHORT),
        .LONG_DLY  (PWR_DLY_LONG),
        .CW        (CW)
    ) u_dly (
        .sel   (dly_sel),
        .limit (pwr_limit)
    );

    cal_seq_fsm #(
        .RUN_LEN (RUN_LEN),
        .CAL_LEN (CAL_LEN),
        .CW      (CW)
    ) u_fsm (
        .clk       (clk),
        .arst_n    (arst_n),
        .req_s     (req_s),
        .pwr_limit (pwr_limit),
        .cal_done  (cal_done),
        .cal_start (cal_start),
        .cal_busy  (cal_busy)
    );
endmodule

// File: rtl/cal_trigger_seq_chk.sv
module cal_trigger_seq_chk #(
    parameter int CAL_LEN = 24
) (
    input logic clk,
    input logic arst_n,
    input logic cal_done,
    input logic cal_start,
    input logic cal_busy
);
    int busy_run;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)        busy_run <= 0;
        else if (cal_start) busy_run <= 1;
        else if (cal_busy)  busy_run <= busy_run + 1;
        else                busy_run <= 0;
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
        cal_start |=> !cal_start); // R6
    AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
        cal_start |-> cal_busy); // R6
    AST_BUSY_RISES_ON_START: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(cal_busy) |-> cal_start); // R6
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!arst_n)
        (cal_busy && !cal_start) |-> (busy_run < CAL_LEN)); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
        (cal_busy && !cal_start && cal_done) |=> !cal_busy); // R7
    AST_NO_START_IN_CAL: assert property (@(posedge clk) disable iff (!arst_n)
        cal_start |-> !$past(cal_busy)); // R8
endmodule

bind cal_trigger_seq cal_trigger_seq_chk #(.CAL_LEN(CAL_LEN)) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .cal_done  (cal_done),
    .cal_start (cal_start),
    .cal_busy  (cal_busy)
);

// File: tb/tb_cal_trigger_seq.sv
module tb_cal_trigger_seq;
    localparam int SHORT = 40;
    localparam int LONG  = 90;
    localparam int N     = 10;
    localparam int CLEN  = 24;

    logic clk = 1'b0, clk_en = 1'b1;
    logic arst_n = 1'b0, cal_req = 1'b0, dly_sel = 1'b0, cal_done = 1'b0;
    logic cal_start, cal_busy;

    int checks = 0, failures = 0;
    int edge_no = 0, n_starts = 0, last_start_edge = -1, busy_len = 0;
    string cur_req = "R1";
    bit finished = 0;

    cal_trigger_seq #(
        .PWR_DLY_SHORT(SHORT), .PWR_DLY_LONG(LONG),
        .RUN_LEN(N), .CAL_LEN(CLEN), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .arst_n(arst_n), .cal_req(cal_req), .dly_sel(dly_sel),
        .cal_done(cal_done), .cal_start(cal_start), .cal_busy(cal_busy)
    );

    initial forever begin
        #10;
        if (clk_en) clk = ~clk;
    end

    // behavioural reference
    int  phase = 0, elapsed = 0, lowrun = 0, highrun = 0, bc = 0;
    bit  qual = 0, m_start = 0, m_s1 = 0, m_s2 = 0, old_s = 0;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            phase = 0; elapsed = 0; lowrun = 0; highrun = 0; bc = 0;
            qual = 0; m_start = 0; m_s1 = 0; m_s2 = 0;
            edge_no = 0;
        end else begin
            edge_no++;
            old_s = m_s2;
            case (phase)
                0: begin
                    if (old_s) begin phase = 1; lowrun = 0; qual = 0; end
                    else if (elapsed == (dly_sel ? LONG : SHORT) - 1) begin phase = 2; m_start = 1; end
                    else elapsed++;
                end
                1: begin
                    if (!qual) begin
                        if (!old_s) begin if (lowrun < N) lowrun++; end
                        else if (lowrun >= N) begin qual = 1; highrun = 1; end
                        else lowrun = 0;
                    end else begin
                        if (!old_s) begin qual = 0; lowrun = 1; end
                        else if (highrun == N - 1) begin phase = 2; m_start = 1; end
                        else highrun++;
                    end
                end
                default: begin
                    if (m_start) begin m_start = 0; bc = 1; end
                    else if (cal_done || bc == CLEN - 1) begin phase = 1; qual = 0; lowrun = 0; end
                    else bc++;
                end
            endcase
            m_s2 = m_s1;
            m_s1 = cal_req;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, track start events
    always @(negedge clk) begin
        if (arst_n) begin
            if (cal_start) begin
                n_starts++;
                last_start_edge = edge_no;
                busy_len = 1;
            end else if (cal_busy) busy_len++;
            chk(cur_req, {30'd0, cal_start, cal_busy},
                {30'd0, (phase == 2 && m_start) ? 1'b1 : 1'b0, (phase == 2) ? 1'b1 : 1'b0});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_start();
        do step(1); while (!cal_start);
    endtask

    task automatic do_reset(bit sel, bit pin);
        cal_req = pin; dly_sel = sel;
        arst_n = 0;
        step(3);
        chk("R1", cal_start, 0);
        chk("R1", cal_busy, 0);
        n_starts = 0; last_start_edge = -1;
        arst_n = 1;
    endtask

    // returns edge at which start is expected
    task automatic qualify(output int exp_edge);
        cal_req = 0; step(N + 2);
        cal_req = 1;
        exp_edge = edge_no + N + 2;
    endtask

    initial begin
        int e, s0;
        // R1: short power-up delay
        cur_req = "R1";
        do_reset(0, 0);
        step(SHORT + CLEN + 5);
        chk("R1", last_start_edge, SHORT);
        chk("R1", n_starts, 1);
        chk("R6", busy_len, CLEN);

        // R4 / R9: qualified request, then pin held high
        cur_req = "R4";
        qualify(e);
        step(N + 2 + CLEN + 4);
        chk("R4", last_start_edge, e);
        chk("R6", busy_len, CLEN);
        cur_req = "R9";
        step(80);
        chk("R9", n_starts, 2);

        // R5: short runs
        cur_req = "R5";
        s0 = n_starts;
        cal_req = 0; step(12); cal_req = 1; step(6);
        cal_req = 0; step(3);  cal_req = 1; step(12);
        cal_req = 0; step(5);  cal_req = 1; step(12);
        cal_req = 0; step(14); cal_req = 1; step(N - 2); cal_req = 0; step(20);
        chk("R5", n_starts, s0);

        // R8: pattern inside busy period ignored
        cur_req = "R8";
        qualify(e);
        wait_start();
        s0 = n_starts;
        cal_req = 0; step(11); cal_req = 1; step(11);
        step(40);
        chk("R8", n_starts, s0);

        // R7: early done
        cur_req = "R7";
        qualify(e);
        wait_start();
        step(4);
        cal_done = 1; step(1); cal_done = 0;
        chk("R7", cal_busy, 0);
        chk("R7", busy_len, 5);
        step(5);

        // R2: long delay
        cur_req = "R2";
        do_reset(1, 0);
        step(LONG + 5);
        chk("R2", last_start_edge, LONG);

        // R3: pin high at power-up
        cur_req = "R3";
        do_reset(0, 1);
        step(LONG + 20);
        chk("R3", n_starts, 0);
        qualify(e);
        step(N + 6);
        chk("R3", last_start_edge, e);
        step(CLEN + 4);

        // R10: clock absent at reset release
        cur_req = "R10";
        @(negedge clk); clk_en = 0;
        cal_req = 0; dly_sel = 0; arst_n = 0;
        #200; arst_n = 1; n_starts = 0; last_start_edge = -1;
        #500; clk_en = 1;
        step(SHORT + 5);
        chk("R10", last_start_edge, SHORT);
        chk("R10", n_starts, 1);
        step(CLEN);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule